// File: doc/BRIEF.md
# Shadow-Stack Store Permission Gate

This block sits beside the store path of a processor pipeline and decides whether a privileged store to the shadow stack may go ahead. On each cycle where a request is strobed, it receives the current privilege level, the execution mode, the operand size, the lock-prefix flag, the enable bits from both configuration registers, and a set of pre-decoded attribute bits for the destination. These cover segment limits, writability, null selectors and the page type.

One cycle later it produces exactly one of two results. The first is a write request to a 64-bit memory bus, carrying the address, the lane-aligned data and the byte enables. The second is a single fault, reported with a class code and an error code. When several fault conditions hold together, only the one with the highest priority is reported. Address translation, descriptor loading and the memory system itself belong to neighbouring blocks.

Top module: `ssw_store_gate`

## Requirements
- R1: Results are registered. A request sampled at a rising edge produces its result on the outputs after that edge. A cycle with `req_valid` low produces `wr_valid=0` and `flt_valid=0` after the next edge. Reset clears both valid outputs.
- R2: An invalid-opcode fault (`flt_code`=1, `flt_err`=0) is raised when the lock prefix is set. It is also raised when `mode` is real (0), virtual-8086 (1), or any code above 4.
- R3: At `cpl`=3 the user enable bits (`u_stk_en`, `u_wr_en`) apply. At `cpl` 0 to 2 the supervisor bits (`s_stk_en`, `s_wr_en`) apply. An invalid-opcode fault is raised when `glob_en` is clear or either selected bit is clear.
- R4: Outside 64-bit mode (`mode` 2 or 3), a data-segment limit violation, a non-writable segment or a null selector raises general protection (`flt_code`=3, `flt_err`=0). A stack-segment limit violation raises a stack fault (`flt_code`=2, `flt_err`=0). In 64-bit mode (`mode`=4) these four inputs have no effect.
- R5: A 64-bit store (`op64`=1) with address bits [2:0] nonzero raises general protection with error 0. A 32-bit store with address bits [1:0] nonzero also raises general protection with error 0.
- R6: In 64-bit mode only, an address whose bits 63 down to 47 are not all equal raises general protection with error 0.
- R7: A page fault (`flt_code`=4) is raised when, at `cpl`=3, `pg_user_shstk` is clear, or, below 3, `pg_sup_shstk` is clear. Its `flt_err` is 0x0042, ORed with 0x0004 at `cpl`=3.
- R8: The fault priority is: invalid opcode, then data-segment general protection, then stack fault, then alignment or canonical general protection, then page fault.
- R9: A 64-bit store drives the full 64-bit source onto `wr_data`, with `wr_be`=0xFF and `wr_addr` equal to the request address.
- R10: A 32-bit store places source bits [31:0] in the upper lane with `wr_be`=0xF0 when address bit 2 is set. Otherwise it places them in the lower lane with `wr_be`=0x0F, and the unused lane is zero.
- R11: For each request, exactly one of `wr_valid` and `flt_valid` is raised. No write is issued when a fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| cpl | input | 2 | Current privilege level |
| mode | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| lock_pfx | input | 1 | Lock prefix present |
| op64 | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| glob_en | input | 1 | Global control-flow enforcement enable |
| u_stk_en | input | 1 | User shadow-stack enable |
| u_wr_en | input | 1 | User shadow-stack write enable |
| s_stk_en | input | 1 | Supervisor shadow-stack enable |
| s_wr_en | input | 1 | Supervisor shadow-stack write enable |
| src_data | input | 64 | Source register value |
| lin_addr | input | 64 | Destination linear address |
| ds_lim_viol | input | 1 | Data-segment limit exceeded |
| ss_lim_viol | input | 1 | Stack-segment limit exceeded |
| seg_ro | input | 1 | Destination segment not writable |
| seg_null | input | 1 | Null selector in data segment register |
| pg_user_shstk | input | 1 | Page is a user shadow-stack page |
| pg_sup_shstk | input | 1 | Page is a supervisor shadow-stack page |
| wr_valid | output | 1 | Write request issued |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Lane-aligned write data |
| wr_be | output | 8 | Byte enables |
| flt_valid | output | 1 | Fault reported |
| flt_code | output | 3 | 0 none, 1 invalid opcode, 2 stack, 3 general protection, 4 page |
| flt_err | output | 16 | Fault error code |

## Verification
The assertions assume that `req_valid` and the context inputs are stable across each sampling edge. They also assume that the context is meaningful only while `req_valid` is high. The stimulus drives every input on the falling edge and holds it for a full cycle. The sweeps cover only the five defined mode codes together with lock, operand size, segment bits, page bits and addresses chosen to hit each alignment and canonical case. Idle cycles are driven with `req_valid` low, so the checker can confirm that no result appears from a stale context.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_V86    = 3'd1,
        MODE_PROT   = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG   = 3'd4
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_SS   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_PF   = 3'd4
    } fault_e;

    // Raw fault conditions, highest priority first.
    typedef struct packed {
        logic ud;
        logic seg_gp;
        logic stk_ss;
        logic addr_gp;
        logic pg_pf;
    } fault_vec_t;

    localparam logic [15:0] PF_ERR_BASE = 16'h0042;
    localparam logic [15:0] PF_ERR_USER = 16'h0004;

    function automatic fault_e pick_fault(fault_vec_t v);
        if (v.ud)           return FLT_UD;
        else if (v.seg_gp)  return FLT_GP;
        else if (v.stk_ss)  return FLT_SS;
        else if (v.addr_gp) return FLT_GP;
        else if (v.pg_pf)   return FLT_PF;
        else                return FLT_NONE;
    endfunction

    function automatic logic [15:0] fault_error(fault_e f, logic user);
        if (f == FLT_PF) return PF_ERR_BASE | (user ? PF_ERR_USER : 16'h0000);
        else             return 16'h0000;
    endfunction

endpackage

// File: rtl/ssw_enable_sel.sv
module ssw_enable_sel
    import ssw_pkg::*;
(
    input  logic [1:0] cpl,
    input  cpu_mode_e  mode,
    input  logic       lock_pfx,
    input  logic       glob_en,
    input  logic       u_stk_en,
    input  logic       u_wr_en,
    input  logic       s_stk_en,
    input  logic       s_wr_en,
    output logic       is_user,
    output logic       ud_fault
);
    logic mode_ok;
    logic sel_stk;
    logic sel_wr;

    always_comb begin
        is_user = (cpl == 2'd3);
        mode_ok = (mode == MODE_PROT) || (mode == MODE_COMPAT) || (mode == MODE_LONG);
        sel_stk = is_user ? u_stk_en : s_stk_en;
        sel_wr  = is_user ? u_wr_en  : s_wr_en;
        ud_fault = lock_pfx || !mode_ok || !glob_en || !sel_stk || !sel_wr;
    end
endmodule

// File: rtl/ssw_addr_check.sv
module ssw_addr_check #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48,
    localparam int HI_W   = ADDR_W - VA_BITS + 1
) (
    input  logic [2:0]      addr_lo,
    input  logic [HI_W-1:0] addr_hi,
    input  logic            op64,
    input  logic            long_mode,
    output logic            addr_fault
);
    logic misalign;
    logic noncanon;

    assign misalign = op64 ? (|addr_lo) : (|addr_lo[1:0]);

    generate
        if (HI_W > 1) begin : g_canon
            assign noncanon = long_mode && !((&addr_hi) || !(|addr_hi));
        end else begin : g_flat
            assign noncanon = 1'b0 & long_mode & addr_hi[0];
        end
    endgenerate

    assign addr_fault = misalign || noncanon;
endmodule

// File: rtl/ssw_lane_steer.sv
module ssw_lane_steer #(
    parameter int DATA_W  = 64,
    localparam int BYTES  = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int HALF_B = BYTES / 2
) (
    input  logic              op64,
    input  logic              upper,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] data,
    output logic [BYTES-1:0]  be
);
    always_comb begin
        if (op64) begin
            data = src;
            be   = '1;
        end else if (upper) begin
            data = {src[HALF_W-1:0], {HALF_W{1'b0}}};
            be   = {{HALF_B{1'b1}}, {HALF_B{1'b0}}};
        end else begin
            data = {{HALF_W{1'b0}}, src[HALF_W-1:0]};
            be   = {{HALF_B{1'b0}}, {HALF_B{1'b1}}};
        end
    end
endmodule

// File: rtl/ssw_store_gate.sv
module ssw_store_gate
    import ssw_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 64,
    parameter int VA_BITS = 48,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_B = $clog2(BYTES) - 1,
    localparam int HI_W   = ADDR_W - VA_BITS + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        cpl,
    input  logic [2:0]        mode,
    input  logic              lock_pfx,
    input  logic              op64,
    input  logic              glob_en,
    input  logic              u_stk_en,
    input  logic              u_wr_en,
    input  logic              s_stk_en,
    input  logic              s_wr_en,
    input  logic [DATA_W-1:0] src_data,
    input  logic [ADDR_W-1:0] lin_addr,
    input  logic              ds_lim_viol,
    input  logic              ss_lim_viol,
    input  logic              seg_ro,
    input  logic              seg_null,
    input  logic              pg_user_shstk,
    input  logic              pg_sup_shstk,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [BYTES-1:0]  wr_be,
    output logic              flt_valid,
    output logic [2:0]        flt_code,
    output logic [15:0]       flt_err
);
    cpu_mode_e   mode_e;
    logic        is_user;
    logic        ud_fault;
    logic        addr_fault;
    logic        seg_mode;
    fault_vec_t  fv;
    fault_e      sel_fault;
    logic [DATA_W-1:0] steer_data;
    logic [BYTES-1:0]  steer_be;

    assign mode_e = cpu_mode_e'(mode);

    ssw_enable_sel u_en (
        .cpl      (cpl),
        .mode     (mode_e),
        .lock_pfx (lock_pfx),
        .glob_en  (glob_en),
        .u_stk_en (u_stk_en),
        .u_wr_en  (u_wr_en),
        .s_stk_en (s_stk_en),
        .s_wr_en  (s_wr_en),
        .is_user  (is_user),
        .ud_fault (ud_fault)
    );

    ssw_addr_check #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_addr (
        .addr_lo    (lin_addr[2:0]),
        .addr_hi    (lin_addr[ADDR_W-1:ADDR_W-HI_W]),
        .op64       (op64),
        .long_mode  (mode_e == MODE_LONG),
        .addr_fault (addr_fault)
    );

    ssw_lane_steer #(.DATA_W(DATA_W)) u_lane (
        .op64  (op64),
        .upper (lin_addr[LANE_B]),
        .src   (src_data),
        .data  (steer_data),
        .be    (steer_be)
    );

    always_comb begin
        seg_mode   = (mode_e != MODE_LONG);
        fv.ud      = ud_fault;
        fv.seg_gp  = seg_mode && (ds_lim_viol || seg_ro || seg_null);
        fv.stk_ss  = seg_mode && ss_lim_viol;
        fv.addr_gp = addr_fault;
        fv.pg_pf   = is_user ? !pg_user_shstk : !pg_sup_shstk;
        sel_fault  = pick_fault(fv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_be     <= '0;
            flt_valid <= 1'b0;
            flt_code  <= FLT_NONE;
            flt_err   <= '0;
        end else begin
            wr_valid  <= req_valid && (sel_fault == FLT_NONE);
            flt_valid <= req_valid && (sel_fault != FLT_NONE);
            flt_code  <= req_valid ? sel_fault : FLT_NONE;
            flt_err   <= req_valid ? fault_error(sel_fault, is_user) : 16'h0000;
            if (req_valid) begin
                wr_addr <= lin_addr;
                wr_data <= steer_data;
                wr_be   <= steer_be;
            end
        end
    end
endmodule

// File: rtl/ssw_store_gate_sva.sv
module ssw_store_gate_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        lock_pfx,
    input logic [2:0]  mode,
    input logic        wr_valid,
    input logic [63:0] wr_addr,
    input logic [7:0]  wr_be,
    input logic        flt_valid,
    input logic [2:0]  flt_code,
    input logic [15:0] flt_err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!wr_valid && !flt_valid));

    assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (wr_valid ^ flt_valid));

    assert_lock_ud_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lock_pfx) |=> (flt_valid && flt_code == 3'd1));

    assert_legacy_ud_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode < 3'd2) |=> (flt_code == 3'd1));

    assert_aligned_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    assert_be_shape_R10: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_be == 8'hFF || wr_be == 8'hF0 || wr_be == 8'h0F));

    assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && flt_code != 3'd4) |-> (flt_err == 16'h0000));
endmodule

bind ssw_store_gate ssw_store_gate_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .lock_pfx  (lock_pfx),
    .mode      (mode),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .flt_valid (flt_valid),
    .flt_code  (flt_code),
    .flt_err   (flt_err)
);

// File: tb/tb_ssw_store_gate.sv
module tb_ssw_store_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  cpl = '0;
    logic [2:0]  mode = '0;
    logic        lock_pfx = 1'b0, op64 = 1'b0;
    logic        glob_en = 1'b0, u_stk_en = 1'b0, u_wr_en = 1'b0, s_stk_en = 1'b0, s_wr_en = 1'b0;
    logic [63:0] src_data = '0, lin_addr = '0;
    logic        ds_lim_viol = 1'b0, ss_lim_viol = 1'b0, seg_ro = 1'b0, seg_null = 1'b0;
    logic        pg_user_shstk = 1'b0, pg_sup_shstk = 1'b0;
    logic        wr_valid, flt_valid;
    logic [63:0] wr_addr, wr_data;
    logic [7:0]  wr_be;
    logic [2:0]  flt_code;
    logic [15:0] flt_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ssw_store_gate dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cpl(cpl), .mode(mode),
        .lock_pfx(lock_pfx), .op64(op64), .glob_en(glob_en), .u_stk_en(u_stk_en),
        .u_wr_en(u_wr_en), .s_stk_en(s_stk_en), .s_wr_en(s_wr_en), .src_data(src_data),
        .lin_addr(lin_addr), .ds_lim_viol(ds_lim_viol), .ss_lim_viol(ss_lim_viol),
        .seg_ro(seg_ro), .seg_null(seg_null), .pg_user_shstk(pg_user_shstk),
        .pg_sup_shstk(pg_sup_shstk), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .flt_valid(flt_valid), .flt_code(flt_code),
        .flt_err(flt_err)
    );

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected result computed from the requirement text.
    task automatic expect_result(string tag);
        logic [2:0]  ec;
        logic [15:0] ee;
        logic        user, legal_mode, en_ok, hi_same, canon_bad, mis;
        user = (cpl == 2'd3);
        legal_mode = (mode == 3'd2 || mode == 3'd3 || mode == 3'd4);
        en_ok = glob_en && (user ? (u_stk_en && u_wr_en) : (s_stk_en && s_wr_en));
        hi_same = (lin_addr[63:47] == 17'h0) || (lin_addr[63:47] == 17'h1FFFF);
        canon_bad = (mode == 3'd4) && !hi_same;
        mis = op64 ? (lin_addr[2:0] != 0) : (lin_addr[1:0] != 0);
        ee = 16'h0;
        if (lock_pfx || !legal_mode || !en_ok) ec = 3'd1;                 // R2 R3
        else if (mode != 3'd4 && (ds_lim_viol || seg_ro || seg_null)) ec = 3'd3; // R4 R8
        else if (mode != 3'd4 && ss_lim_viol) ec = 3'd2;                  // R4
        else if (mis || canon_bad) ec = 3'd3;                             // R5 R6
        else if (user ? !pg_user_shstk : !pg_sup_shstk) begin             // R7
            ec = 3'd4;
            ee = 16'h0042 | (user ? 16'h0004 : 16'h0000);
        end else ec = 3'd0;
        @(posedge clk);
        #1;
        check({tag, " R11 wr_valid"}, 128'(wr_valid), 128'(ec == 3'd0));
        check({tag, " R8 fault"}, {flt_valid, flt_code, flt_err}, {ec != 0, ec, ee});
        if (ec == 3'd0) begin
            if (op64) begin
                check("R9 data/be/addr", {wr_data, wr_be}, {src_data, 8'hFF});
                check("R9 addr", 128'(wr_addr), 128'(lin_addr));
            end else if (lin_addr[2])
                check("R10 upper lane", {wr_data, wr_be}, {src_data[31:0], 32'h0, 8'hF0});
            else
                check("R10 lower lane", {wr_data, wr_be}, {32'h0, src_data[31:0], 8'h0F});
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        lock_pfx = 1'b0;
        @(posedge clk);
        #1;
        check("R1 idle", {wr_valid, flt_valid}, 2'b00);
    endtask

    function automatic logic [63:0] pick_addr(int k);
        case (k)
            0: return 64'h0000_0000_0000_1000;
            1: return 64'h0000_0000_0000_1004;
            2: return 64'h0000_0000_0000_1002;
            3: return 64'h0000_0000_0000_1001;
            4: return 64'h0000_8000_0000_1000;
            default: return 64'hFFFF_8000_0000_1008;
        endcase
    endfunction

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {wr_valid, flt_valid, flt_code}, 5'b0);
        @(negedge clk);
        rst = 1'b0;
        idle_check();

        // R3: enable selection sweep
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 32; e++) begin
                for (int m = 2; m < 5; m++) begin
                    @(negedge clk);
                    req_valid = 1'b1;
                    cpl = 2'(c); mode = 3'(m); lock_pfx = 1'b0; op64 = 1'b1;
                    {glob_en, u_stk_en, u_wr_en, s_stk_en, s_wr_en} = 5'(e);
                    ds_lim_viol = 0; ss_lim_viol = 0; seg_ro = 0; seg_null = 0;
                    pg_user_shstk = 1'b1; pg_sup_shstk = 1'b1;
                    lin_addr = 64'h2000 + 64'(e * 8);
                    src_data = 64'hA5A5_0000_0000_0000 | 64'(e);
                    expect_result("R3");
                end
            end
            idle_check();
        end

        // Main sweep: mode, lock, size, segment, page, address (R2 R4-R10)
        glob_en = 1; u_stk_en = 1; u_wr_en = 1; s_stk_en = 1; s_wr_en = 1;
        for (int c = 0; c < 4; c++)
        for (int m = 0; m < 5; m++) begin
            for (int l = 0; l < 2; l++)
            for (int o = 0; o < 2; o++)
            for (int s = 0; s < 16; s++)
            for (int p = 0; p < 4; p++)
            for (int a = 0; a < 6; a++) begin
                @(negedge clk);
                req_valid = 1'b1;
                cpl = 2'(c); mode = 3'(m); lock_pfx = l[0]; op64 = o[0];
                {ds_lim_viol, ss_lim_viol, seg_ro, seg_null} = 4'(s);
                {pg_user_shstk, pg_sup_shstk} = 2'(p);
                lin_addr = pick_addr(a);
                src_data = 64'h1122_3344_5566_7788 ^ 64'(s * 977 + a * 31 + p);
                expect_result("R4");
            end
            idle_check();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule